// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer with a small word-addressed register bus. A 32-bit counter counts upward on a functional clock. After reset it is frozen. Software starts it by writing two ordered key words and stops it by writing a different ordered pair.

Software keeps the watchdog alive by loading a reload value and then writing the trigger register with a value that differs from its last content. If the counter is not reloaded in time, it wraps past all ones. The wrap raises an overflow interrupt and drives a reset request for a fixed number of cycles. A second compare value raises an early-warning interrupt before that point.

Writes to the control, load, trigger and key registers are posted. Each one is held in a shadow copy and committed a fixed number of cycles later. Software can poll a pending flag for each of these registers. The block also offers a soft reset with a completion flag, a prescaler, and a freeze of the count while a debug-halt input is high.

Top module: `keyseq_wdt`

## Requirements
- R1: The counter advances only after the key register commits 0x0000BBBB and then 0x00004444 as consecutive key writes. Word addresses are: 0 config, 1 status, 2 interrupt status, 3 interrupt enable, 4 control, 5 count, 6 load, 7 trigger, 8 key, 9 pending, 10 delay.
- R2: A committed 0x0000AAAA followed by 0x00005555 on the key register freezes the counter at its current value.
- R3: A key word that arrives out of order, or any other key value, discards the partial sequence and leaves the run state unchanged.
- R4: While running, the counter rises by one per tick. Control bit 0 enables the prescaler and bits [3:1] hold the ratio r. With the prescaler on, a tick occurs every 2^r cycles; with it off, a tick occurs on every cycle.
- R5: A committed trigger write whose value differs from the stored trigger value copies the load register into the counter. A trigger write with an equal value leaves the counter alone.
- R6: A tick taken at 0xFFFFFFFF reloads the counter from the load register and sets interrupt-status bit 0. It also holds rst_req high for RST_PULSE cycles.
- R7: A tick that brings the counter to the delay value sets interrupt-status bit 1. irq_ovf and irq_dly each follow their status bit masked by enable bits 0 and 1. Writing 1 to a status bit clears it.
- R8: Pending register bits 0, 1, 2 and 3 belong to control, load, trigger and key. Each bit is set from the write until the write commits COMMIT_LAT cycles later, and only then does the written value take effect.
- R9: Writing config bit 1 returns all state to its reset value. Status bit 0 then reads 0 for COMMIT_LAT cycles, and every bus write in that window is ignored.
- R10: When config bit 0 is 0, the counter and the prescaler hold while emu_halt is high. When the bit is 1, emu_halt has no effect.
- R11: After reset the counter, load, trigger and pending registers read 0, the counter is stopped, status bit 0 reads 1, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| emu_halt | input | 1 | Debug halt request |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_dly | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Reset request pulse after overflow |

## Verification
The embedded properties hold on every cycle and cover five things:
- the counter does not move while stopped;
- it steps by at most one while running;
- a pending flag rises only after a write to its own register;
- the reset request starts only from an all-ones count, and the early-warning flag only when the count equals the delay value;
- a soft reset clears the done flag.

Ordering and content can only be shown by the bench scenarios, which compare the block against a behavioural model every cycle. These cover key-sequence ordering and cancellation, reload on an equal or unequal trigger value, prescaler spacing, the debug freeze, and the soft-reset window that ignores writes.

// File: rtl/keyseq_wdt.sv
module keyseq_wdt #(
  parameter int DATA_W     = 32,
  parameter int RATIO_W    = 3,
  parameter int COMMIT_LAT = 2,
  parameter int RST_PULSE  = 8,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              emu_halt,
  output logic              irq_ovf,
  output logic              irq_dly,
  output logic              rst_req
);
  localparam int PRE_W  = (1 << RATIO_W) - 1;
  localparam int LAT_W  = $clog2(COMMIT_LAT + 1);
  localparam int RP_W   = $clog2(RST_PULSE + 1);
  localparam int CTRL_W = RATIO_W + 1;
  localparam int NSLOT  = 4;

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_DLY  = ADDR_W'(10);

  localparam logic [DATA_W-1:0] K_STOP_A  = DATA_W'(16'hAAAA);
  localparam logic [DATA_W-1:0] K_STOP_B  = DATA_W'(16'h5555);
  localparam logic [DATA_W-1:0] K_START_A = DATA_W'(16'hBBBB);
  localparam logic [DATA_W-1:0] K_START_B = DATA_W'(16'h4444);

  typedef enum logic [1:0] {KS_IDLE, KS_STOP_ARMED, KS_START_ARMED} key_e;

  logic [NSLOT-1:0]  pend_q;
  logic [DATA_W-1:0] post_d   [NSLOT];
  logic [LAT_W-1:0]  post_cnt [NSLOT];
  logic [NSLOT-1:0]  wr_slot, fire;

  logic [LAT_W-1:0]  srst_cnt;
  logic              emu_free_q, run_q;
  key_e              key_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] count_q, load_q, trig_q, delay_q;
  logic [1:0]        ist_q, ien_q;
  logic [RP_W-1:0]   rp_cnt;

  wire wr_ok   = bus_wr && (srst_cnt == '0);
  wire srst_go = wr_ok && (bus_addr == A_CFG) && bus_wdata[1];

  assign wr_slot = {wr_ok && bus_addr == A_KEY,  wr_ok && bus_addr == A_TRIG,
                    wr_ok && bus_addr == A_LOAD, wr_ok && bus_addr == A_CTRL};

  always_comb
    for (int k = 0; k < NSLOT; k++) fire[k] = pend_q[k] && (post_cnt[k] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int k = 0; k < NSLOT; k++) begin
        post_d[k]   <= '0;
        post_cnt[k] <= '0;
      end
    end else if (srst_go) begin
      pend_q <= '0;
    end else begin
      for (int k = 0; k < NSLOT; k++) begin
        if (wr_slot[k]) begin
          pend_q[k]   <= 1'b1;
          post_d[k]   <= bus_wdata;
          post_cnt[k] <= LAT_W'(COMMIT_LAT - 1);
        end else if (fire[k]) begin
          pend_q[k] <= 1'b0;
        end else if (pend_q[k]) begin
          post_cnt[k] <= post_cnt[k] - 1'b1;
        end
      end
    end
  end

  wire               pre_en   = ctrl_q[0];
  wire [RATIO_W-1:0] ratio    = ctrl_q[CTRL_W-1:1];
  wire [PRE_W-1:0]   pre_mask = ~({PRE_W{1'b1}} << ratio);
  wire               active   = run_q && (emu_free_q || !emu_halt);
  wire               tick     = active && (!pre_en || pre_q >= pre_mask);
  wire               trig_hit = fire[2] && (post_d[2] != trig_q);
  wire               at_top   = (count_q == '1);
  wire               ovf_ev   = tick && !trig_hit && at_top;
  wire               dly_ev   = tick && !trig_hit && !at_top &&
                                (count_q + DATA_W'(1) == delay_q);
  wire [1:0]         ist_clr  = (wr_ok && bus_addr == A_IST) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_cnt <= '0;
      emu_free_q <= 1'b0; run_q <= 1'b0; key_q <= KS_IDLE;
      ctrl_q <= '0; pre_q <= '0; count_q <= '0; load_q <= '0;
      trig_q <= '0; delay_q <= '0; ist_q <= '0; ien_q <= '0; rp_cnt <= '0;
    end else if (srst_go) begin
      srst_cnt <= LAT_W'(COMMIT_LAT);
      emu_free_q <= 1'b0; run_q <= 1'b0; key_q <= KS_IDLE;
      ctrl_q <= '0; pre_q <= '0; count_q <= '0; load_q <= '0;
      trig_q <= '0; delay_q <= '0; ist_q <= '0; ien_q <= '0; rp_cnt <= '0;
    end else begin
      if (srst_cnt != '0) srst_cnt <= srst_cnt - 1'b1;
      if (active) pre_q <= tick ? '0 : pre_q + 1'b1;
      if (trig_hit)    count_q <= load_q;
      else if (ovf_ev) count_q <= load_q;
      else if (tick)   count_q <= count_q + DATA_W'(1);
      if (ovf_ev)             rp_cnt <= RP_W'(RST_PULSE);
      else if (rp_cnt != '0)  rp_cnt <= rp_cnt - 1'b1;
      ist_q <= (ist_q & ~ist_clr) | {dly_ev, ovf_ev};
      if (fire[0]) ctrl_q <= post_d[0][CTRL_W-1:0];
      if (fire[1]) load_q <= post_d[1];
      if (fire[2]) trig_q <= post_d[2];
      if (fire[3]) begin
        key_q <= KS_IDLE;
        if (post_d[3] == K_STOP_A) key_q <= KS_STOP_ARMED;
        else if (post_d[3] == K_START_A) key_q <= KS_START_ARMED;
        else if (post_d[3] == K_STOP_B && key_q == KS_STOP_ARMED) run_q <= 1'b0;
        else if (post_d[3] == K_START_B && key_q == KS_START_ARMED) run_q <= 1'b1;
      end
      if (wr_ok && bus_addr == A_CFG) emu_free_q <= bus_wdata[0];
      if (wr_ok && bus_addr == A_IEN) ien_q <= bus_wdata[1:0];
      if (wr_ok && bus_addr == A_DLY) delay_q <= bus_wdata;
    end
  end

  assign irq_ovf = ist_q[0] & ien_q[0];
  assign irq_dly = ist_q[1] & ien_q[1];
  assign rst_req = (rp_cnt != '0);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:  bus_rdata[0] = emu_free_q;
      A_STAT: bus_rdata[0] = (srst_cnt == '0);
      A_IST:  bus_rdata[1:0] = ist_q;
      A_IEN:  bus_rdata[1:0] = ien_q;
      A_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_CNT:  bus_rdata = count_q;
      A_LOAD: bus_rdata = load_q;
      A_TRIG: bus_rdata = trig_q;
      A_PEND: bus_rdata[NSLOT-1:0] = pend_q;
      A_DLY:  bus_rdata = delay_q;
      default: bus_rdata = '0;
    endcase
  end

  logic unused_hi;
  assign unused_hi = ^{post_d[0][DATA_W-1:CTRL_W], bus_wdata};

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !trig_hit && !srst_go) |=> (count_q == $past(count_q)));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !trig_hit && !srst_go && !at_top) |=> (count_q - $past(count_q) <= DATA_W'(1)));

  p_pend_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[1]) |-> $past(bus_wr && bus_addr == A_LOAD));

  p_pulse_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(count_q) == '1));

  p_dly_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_q[1]) |-> (count_q == $past(delay_q)));

  p_srst_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_go |=> (bus_addr != A_STAT || bus_rdata[0] == 1'b0));
endmodule

// File: tb/tb_keyseq_wdt.sv
`timescale 1ns/1ps
module tb_keyseq_wdt;
  localparam int LAT = 2;
  localparam int PULSE = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, emu_halt = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_ovf, irq_dly, rst_req;

  keyseq_wdt #(.DATA_W(32), .RATIO_W(3), .COMMIT_LAT(LAT), .RST_PULSE(PULSE), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .emu_halt(emu_halt), .irq_ovf(irq_ovf), .irq_dly(irq_dly),
    .rst_req(rst_req));

  always #2.5 clk = ~clk;

  typedef struct {int slot; logic [31:0] d; int due;} post_t;
  post_t pq[$];
  logic m_run, m_free, m_pen;
  logic [2:0] m_ratio;
  logic [31:0] m_cnt, m_load, m_trig, m_dly;
  logic [1:0] m_ist, m_ien, clr;
  int m_pre, m_rst, m_srst, m_key, cyc;
  int vecs = 0, fails = 0;
  bit done_flag = 0;
  logic w_ok, act, tick, hit, ovf, dly;
  logic f [4];
  logic [31:0] fd [4];
  int msk;

  task automatic m_clear();
    m_run = 0; m_free = 0; m_pen = 0; m_ratio = 0; m_cnt = 0; m_load = 0; m_trig = 0;
    m_dly = 0; m_ist = 0; m_ien = 0; m_pre = 0; m_rst = 0; m_key = 0; pq.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_srst = 0; cyc = 0;
    end else begin
      cyc++;
      w_ok = bus_wr && m_srst == 0;
      if (w_ok && bus_addr == 0 && bus_wdata[1]) begin
        m_clear(); m_srst = LAT;
      end else begin
        for (int k = 0; k < 4; k++) begin f[k] = 0; fd[k] = 0; end
        for (int i = pq.size() - 1; i >= 0; i--)
          if (pq[i].due == cyc) begin f[pq[i].slot] = 1; fd[pq[i].slot] = pq[i].d; pq.delete(i); end
        act = m_run && (m_free || !emu_halt);
        msk = (1 << m_ratio) - 1;
        tick = act && (!m_pen || m_pre >= msk);
        if (act) m_pre = tick ? 0 : m_pre + 1;
        hit = f[2] && fd[2] != m_trig;
        ovf = 0; dly = 0;
        if (hit) m_cnt = m_load;
        else if (tick) begin
          if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = m_load; ovf = 1; end
          else begin m_cnt = m_cnt + 1; if (m_cnt == m_dly) dly = 1; end
        end
        m_rst = ovf ? PULSE : (m_rst > 0 ? m_rst - 1 : 0);
        clr = (w_ok && bus_addr == 2) ? bus_wdata[1:0] : 2'b00;
        m_ist = (m_ist & ~clr) | {dly, ovf};
        if (f[0]) begin m_pen = fd[0][0]; m_ratio = fd[0][3:1]; end
        if (f[1]) m_load = fd[1];
        if (f[2]) m_trig = fd[2];
        if (f[3]) begin
          if (fd[3] == 32'hAAAA) m_key = 1;
          else if (fd[3] == 32'hBBBB) m_key = 2;
          else begin
            if (fd[3] == 32'h5555 && m_key == 1) m_run = 0;
            if (fd[3] == 32'h4444 && m_key == 2) m_run = 1;
            m_key = 0;
          end
        end
        if (w_ok) case (bus_addr)
          4'd0: m_free = bus_wdata[0];
          4'd3: m_ien = bus_wdata[1:0];
          4'd10: m_dly = bus_wdata;
          4'd4: pq.push_back('{0, bus_wdata, cyc + LAT});
          4'd6: pq.push_back('{1, bus_wdata, cyc + LAT});
          4'd7: pq.push_back('{2, bus_wdata, cyc + LAT});
          4'd8: pq.push_back('{3, bus_wdata, cyc + LAT});
          default: ;
        endcase
        if (m_srst > 0) m_srst--;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] r = 0;
    case (a)
      4'd0: r[0] = m_free;
      4'd1: r[0] = (m_srst == 0);
      4'd2: r[1:0] = m_ist;
      4'd3: r[1:0] = m_ien;
      4'd4: r[3:0] = {m_ratio, m_pen};
      4'd5: r = m_cnt;
      4'd6: r = m_load;
      4'd7: r = m_trig;
      4'd9: foreach (pq[i]) r[pq[i].slot] = 1'b1;
      4'd10: r = m_dly;
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cyc > 0 && !done_flag) begin
      vecs++;
      if ({irq_ovf, irq_dly, rst_req} !== {m_ist[0] & m_ien[0], m_ist[1] & m_ien[1], m_rst != 0}) begin
        fails++;
        $display("FAIL R6/R7 outputs ovf,dly,rst actual %b expected %b", {irq_ovf, irq_dly, rst_req},
                 {m_ist[0] & m_ien[0], m_ist[1] & m_ien[1], m_rst != 0});
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] a, input string tag);
    bus_addr = a; #1;
    vecs++;
    if (bus_rdata !== m_read(a)) begin
      fails++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, bus_rdata, m_read(a));
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk(5, "R11"); chk(9, "R11"); chk(1, "R11"); chk(2, "R11");
    wr(6, 100); chk(9, "R8"); idle(3); chk(9, "R8"); chk(6, "R8");
    wr(7, 1); idle(3); chk(5, "R5");
    idle(10); chk(5, "R1");
    wr(8, 32'hBBBB); idle(3); chk(5, "R1");
    wr(8, 32'h4444); idle(8); chk(5, "R1");
    wr(8, 32'h5555); idle(3); wr(8, 32'hAAAA); idle(3);
    wr(8, 32'h1234); idle(3); wr(8, 32'h5555); idle(5); chk(5, "R3");
    wr(8, 32'hAAAA); idle(3); wr(8, 32'h5555); idle(3); chk(5, "R2"); idle(10); chk(5, "R2");
    wr(7, 1); idle(3); chk(5, "R5");
    wr(6, 500); idle(3); wr(7, 2); idle(3); chk(5, "R5");
    wr(4, 32'h5); idle(3); chk(4, "R4");
    wr(8, 32'hBBBB); idle(3); wr(8, 32'h4444); idle(20);
    for (int i = 0; i < 6; i++) begin chk(5, "R4"); idle(1); end
    wr(3, 3); wr(10, m_cnt + 8); idle(60); chk(2, "R7");
    wr(2, 2); chk(2, "R7");
    wr(4, 0); idle(3); wr(6, 32'hFFFF_FFF0); idle(3); wr(7, 3); idle(30); chk(2, "R6"); chk(5, "R6");
    wr(2, 1); wr(3, 0); idle(2); chk(3, "R7");
    emu_halt = 1; idle(5); chk(5, "R10"); idle(5); chk(5, "R10");
    wr(0, 1); idle(5); chk(5, "R10"); emu_halt = 0;
    wr(0, 2); chk(1, "R9"); wr(6, 77); idle(3); chk(1, "R9"); chk(6, "R9"); chk(5, "R9"); chk(0, "R9");
    idle(2);
    finish_run();
  end
endmodule